// File: doc/BRIEF.md
# NAND Two-Phase Access Sequencer

This block turns single-beat bus requests into byte-wide NAND flash pin activity. The bus address carries the control information. Bit 19 splits every access into one of two kinds. A command access drives a start opcode onto the device. It then sends a chosen number of address bytes, taken from the write data, and can finish with a closing opcode. A data access moves a full bus word to or from the device one byte at a time. It can close with an opcode and then wait for the device's ready/busy line. It can also release the chip enable once it finishes.

A whole flash operation is a series of such accesses, for example a command access followed by one or more data accesses. The chip enable stays asserted from one access to the next. It is dropped only when a data access asks for that, which software does on the final transfer of an operation. A data access can also raise a one-cycle strobe that marks the final transfer for an external error-correction engine.

The request side is valid/ready. The master raises `req_valid` and holds the address, direction and write data unchanged until it sees `req_ready`. `req_ready` is high for exactly one cycle, when the whole pin sequence has finished. In that same cycle `rsp_rdata` carries the read word and `ecc_last` carries the strobe. The block stalls the master for as long as the flash sequence takes, which is its only form of back-pressure.

Top module: `nand_phase_seq`

## Requirements
- R1: Address bit 19 selects the access kind. 0 means a command access and 1 means a data access. A command access begins with a CLE byte and a data access begins with data bytes.
- R2: The low log2(CHIPS) bits of the chip field [31:24] select which active-low `nand_ce_n` bit goes low when an access starts. The rest of the chip field is ignored, and at most one chip enable is low at any time.
- R3: A command access first sends the start opcode from address bits [10:3], with CLE high and ALE low.
- R4: A command access then sends N address bytes with ALE high, where N comes from address bits [23:21]. They are taken from `req_wdata` least significant byte first. When N is 0, no address byte is sent.
- R5: When address bit 20 is set, the closing opcode from bits [18:11] is sent with CLE high after all other bytes of the access. When bit 20 is clear, no closing opcode is sent.
- R6: A data write sends all DATA_W/8 bytes of `req_wdata`, least significant byte first, with CLE and ALE low.
- R7: A data read makes DATA_W/8 RE pulses. Byte k returned by the device lands in `rsp_rdata[8k+7:8k]`, and `nand_io_oe` is low while RE is low.
- R8: A data access that sends a closing opcode acknowledges only after `nand_rb` has been seen high, following a guard delay after that opcode.
- R9: A data access with address bit 21 set raises every chip enable on completion. Any other access, including a command access with bit 21 set, leaves the selected chip enabled.
- R10: `ecc_last` is high with `req_ready` for a data access with address bit 10 set. It stays low in every other cycle, including command accesses whose start opcode has bit 10 set.
- R11: `req_ready` is high for a single cycle per access, only once its pin sequence is finished.
- R12: Each WE or RE pulse is low for exactly LOW_T clocks (default 2), and the strobe stays high at least HIGH_T clocks (default 2) between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request completed and accepted (one cycle) |
| req_addr | input | 32 | Encoded control address |
| req_write | input | 1 | 1 for a data write, 0 for a data read |
| req_wdata | input | DATA_W | Write data, or address bytes in a command access |
| rsp_rdata | output | DATA_W | Read word, valid with req_ready |
| ecc_last | output | 1 | Final-transfer strobe for error correction |
| nand_ce_n | output | CHIPS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
The hardest case to reach from the ports is the ready/busy wait. The acknowledge must be held back until the device line rises, and that line only falls in answer to a closing opcode. The bench's device model drops `nand_rb` for twenty cycles when it sees the closing opcode of an armed data access. The bench then compares the acknowledge time against the rise time it recorded. Chip-field aliasing and address bits whose meaning depends on the phase, such as bit 21 and bit 10, are also exercised. Each case uses an address whose bit is set in the phase where it must have no effect.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int PHASE_BIT  = 19;
  localparam int END_OK_BIT = 20;
  localparam int DROP_BIT   = 21;
  localparam int TAIL_BIT   = 10;
  localparam int CHIP_LSB   = 24;
  localparam int NADDR_LSB  = 21;
  localparam int ENDC_LSB   = 11;
  localparam int STARTC_LSB = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_DATA, ST_END, ST_GUARD, ST_BUSY, ST_ACK
  } seq_state_t;

  typedef struct packed {
    logic       data_ph;
    logic [7:0] chip;
    logic [2:0] n_addr;
    logic       end_ok;
    logic [7:0] end_cmd;
    logic [7:0] start_cmd;
    logic       drop_cs;
    logic       ecc_tail;
  } acc_ctl_t;

endpackage

// File: rtl/nand_addr_decode.sv
module nand_addr_decode
  import nand_seq_pkg::*;
(
  input  logic [31:0] addr,
  output acc_ctl_t    ctl
);
  logic is_data;
  assign is_data = addr[PHASE_BIT];

  always_comb begin
    ctl.data_ph   = is_data;
    ctl.chip      = addr[CHIP_LSB +: 8];
    ctl.end_ok    = addr[END_OK_BIT];
    ctl.end_cmd   = addr[ENDC_LSB +: 8];
    // phase-dependent fields: meaningless bits are forced to zero
    ctl.n_addr    = is_data ? 3'd0 : addr[NADDR_LSB +: 3];
    ctl.start_cmd = is_data ? 8'd0 : addr[STARTC_LSB +: 8];
    ctl.drop_cs   = is_data & addr[DROP_BIT];
    ctl.ecc_tail  = is_data & addr[TAIL_BIT];
  end
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int LOW_T  = 2,
  parameter int HIGH_T = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd,
  input  logic [7:0] io_in,
  output logic       busy,
  output logic       done,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] rbyte
);
  localparam int MAX_T = (LOW_T > HIGH_T) ? LOW_T : HIGH_T;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(LOW_T - 1);
  localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(HIGH_T - 2);

  logic             lo_q;
  logic             rd_q;
  logic [CNT_W-1:0] cnt;

  // busy is dropped one cycle early so the next pulse starts after HIGH_T
  assign done = busy && !lo_q && (cnt == HIGH_END);
  assign we_n = !(busy && lo_q && !rd_q);
  assign re_n = !(busy && lo_q && rd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      lo_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt   <= '0;
      rbyte <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      lo_q <= 1'b1;
      rd_q <= rd;
      cnt  <= '0;
    end else if (busy) begin
      if (lo_q) begin
        if (cnt == LOW_END) begin
          lo_q <= 1'b0;
          cnt  <= '0;
          if (rd_q) rbyte <= io_in;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (done) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R12
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |=> !we_n);
  // R12
  re_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |=> !re_n);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
endmodule

// File: rtl/nand_cs_ctrl.sv
module nand_cs_ctrl #(
  parameter int CHIPS = 4,
  localparam int CS_W = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CS_W-1:0]  sel,
  input  logic             drop,
  output logic [CHIPS-1:0] ce_n
);
  for (genvar i = 0; i < CHIPS; i++) begin : g_ce
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ce_n[i] <= 1'b1;
      else if (take) ce_n[i] <= (sel != CS_W'(i));
      else if (drop) ce_n[i] <= 1'b1;
    end
  end

  // R2
  ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  // R9
  ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !take) |=> (&ce_n));
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHIPS   = 4,
  parameter int LOW_T   = 2,
  parameter int HIGH_T  = 2,
  parameter int GUARD_T = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ecc_last,
  output logic [CHIPS-1:0]  nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = $clog2(BYTES);
  localparam int CS_W  = $clog2(CHIPS);
  localparam int GCW   = $clog2(GUARD_T + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  seq_state_t        state;
  acc_ctl_t          dec, ctl;
  logic              wr_q;
  logic [DATA_W-1:0] wbuf, rbuf;
  logic [IDX_W-1:0]  idx;
  logic [GCW-1:0]    gcnt;
  logic              byte_st, p_start, p_busy, p_done, p_rd;
  logic [7:0]        p_rbyte;
  logic              accept, release_cs;
  logic [IDX_W-1:0]  addr_last;

  nand_addr_decode u_dec (.addr(req_addr), .ctl(dec));

  assign accept     = (state == ST_IDLE) && req_valid;
  assign release_cs = (state == ST_ACK) && ctl.drop_cs;

  nand_cs_ctrl #(.CHIPS(CHIPS)) u_cs (
    .clk(clk), .rst_n(rst_n), .take(accept), .sel(dec.chip[CS_W-1:0]),
    .drop(release_cs), .ce_n(nand_ce_n)
  );

  assign byte_st = (state == ST_START) || (state == ST_ADDR) ||
                   (state == ST_DATA)  || (state == ST_END);
  assign p_start = byte_st && !p_busy;
  assign p_rd    = (state == ST_DATA) && !wr_q;

  nand_strobe_gen #(.LOW_T(LOW_T), .HIGH_T(HIGH_T)) u_stb (
    .clk(clk), .rst_n(rst_n), .start(p_start), .rd(p_rd), .io_in(nand_io_in),
    .busy(p_busy), .done(p_done), .we_n(nand_we_n), .re_n(nand_re_n),
    .rbyte(p_rbyte)
  );

  assign addr_last = IDX_W'(ctl.n_addr) - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctl   <= '0;
      wr_q  <= 1'b0;
      wbuf  <= '0;
      rbuf  <= '0;
      idx   <= '0;
      gcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          ctl   <= dec;
          wr_q  <= req_write;
          wbuf  <= req_wdata;
          idx   <= '0;
          state <= dec.data_ph ? ST_DATA : ST_START;
        end
        ST_START: if (p_done) begin
          if (ctl.n_addr != 3'd0) state <= ST_ADDR;
          else if (ctl.end_ok)    state <= ST_END;
          else                    state <= ST_ACK;
        end
        ST_ADDR: if (p_done) begin
          if (idx == addr_last) state <= ctl.end_ok ? ST_END : ST_ACK;
          else                  idx <= idx + 1'b1;
        end
        ST_DATA: if (p_done) begin
          if (!wr_q) rbuf[{idx, 3'b000} +: 8] <= p_rbyte;
          if (idx == LAST_IDX) state <= ctl.end_ok ? ST_END : ST_ACK;
          else                 idx <= idx + 1'b1;
        end
        ST_END: if (p_done) begin
          gcnt  <= '0;
          state <= ctl.data_ph ? ST_GUARD : ST_ACK;
        end
        ST_GUARD: begin
          if (gcnt == GCW'(GUARD_T - 1)) state <= ST_BUSY;
          else                           gcnt  <= gcnt + 1'b1;
        end
        ST_BUSY: if (nand_rb) state <= ST_ACK;
        ST_ACK:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // pin decode from registered state
  always_comb begin
    nand_io_out = 8'h00;
    unique case (state)
      ST_START: nand_io_out = ctl.start_cmd;
      ST_ADDR,
      ST_DATA:  nand_io_out = wbuf[{idx, 3'b000} +: 8];
      ST_END:   nand_io_out = ctl.end_cmd;
      default:  nand_io_out = 8'h00;
    endcase
  end

  assign nand_cle   = (state == ST_START) || (state == ST_END);
  assign nand_ale   = (state == ST_ADDR);
  assign nand_io_oe = (state == ST_START) || (state == ST_ADDR) ||
                      (state == ST_END) || ((state == ST_DATA) && wr_q);
  assign req_ready  = (state == ST_ACK);
  assign ecc_last   = (state == ST_ACK) && ctl.ecc_tail;
  assign rsp_rdata  = rbuf;

  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R11
  ready_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BUSY) && !nand_rb) |=> !req_ready);
  // R10
  tail_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_last |-> req_ready);
  // R7
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  // R2
  ce_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !(&nand_ce_n));
endmodule

// File: tb/sim_nand_phase_seq.sv
`timescale 1ns/1ps
module sim_nand_phase_seq;
  localparam int DATA_W = 64;
  localparam int CHIPS  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, ecc_last, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [DATA_W-1:0] rsp_rdata;
  logic [CHIPS-1:0] nand_ce_n;
  logic [7:0] nand_io_out, nand_io_in;
  logic nand_rb = 1'b1;

  always #2 clk = ~clk;

  nand_phase_seq #(.DATA_W(DATA_W), .CHIPS(CHIPS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .ecc_last(ecc_last), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  typedef struct {
    logic       cle;
    logic       ale;
    logic [7:0] b;
    int         chip;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit arm_busy = 0;
  time rb_rise = 0, t_endcmd = 0;
  int rd_ctr = 0;
  event ev_busy;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  assign nand_io_in = pat(rd_ctr);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // device model: scoreboard monitor on each write strobe rise
  always @(posedge nand_we_n) begin
    exp_t it;
    if (rst_n) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5", "unexpected write strobe", {56'd0, nand_io_out}, 0);
      end else begin
        it = exp_q.pop_front();
        chk(nand_io_out == it.b, it.tag, "byte", {56'd0, nand_io_out}, {56'd0, it.b});
        chk({nand_cle, nand_ale} == {it.cle, it.ale}, it.tag, "cle/ale",
            {62'd0, nand_cle, nand_ale}, {62'd0, it.cle, it.ale});
        chk(nand_ce_n == ~(CHIPS'(1) << it.chip), "R2", "ce during byte",
            {60'd0, nand_ce_n}, {60'd0, ~(CHIPS'(1) << it.chip)});
        if (arm_busy && it.cle) begin
          arm_busy = 0;
          t_endcmd = $time;
          ->ev_busy;
        end
      end
    end
  end

  initial begin
    forever begin
      @ev_busy;
      nand_rb = 1'b0;
      repeat (20) @(posedge clk);
      #1 nand_rb = 1'b1;
      rb_rise = $time;
    end
  end

  // R12 strobe widths
  time we_fall = 0, we_rise = 0, re_fall = 0, re_rise = 0;
  always @(negedge nand_we_n) if (rst_n) begin
    we_fall = $time;
    if (we_rise != 0) chk(($time - we_rise) >= 8, "R12", "we high time", $time - we_rise, 8);
  end
  always @(posedge nand_we_n) if (rst_n && we_fall != 0) begin
    we_rise = $time;
    chk(($time - we_fall) == 8, "R12", "we low time", $time - we_fall, 8);
  end
  always @(negedge nand_re_n) if (rst_n) begin
    re_fall = $time;
    chk(nand_io_oe == 1'b0, "R7", "oe during read", {63'd0, nand_io_oe}, 0);
    if (re_rise != 0) chk(($time - re_rise) >= 8, "R12", "re high time", $time - re_rise, 8);
  end
  always @(posedge nand_re_n) if (rst_n && re_fall != 0) begin
    re_rise = $time;
    chk(($time - re_fall) == 8, "R12", "re low time", $time - re_fall, 8);
    #1 rd_ctr++;
  end

  function automatic logic [31:0] mk_cmd(input logic [7:0] chip, input logic [2:0] n,
      input logic endv, input logic [7:0] endc, input logic [7:0] stc);
    return {chip, n, endv, 1'b0, endc, stc, 3'b000};
  endfunction

  function automatic logic [31:0] mk_dat(input logic [7:0] chip, input logic clr,
      input logic endv, input logic [7:0] endc, input logic tail);
    return {chip, 2'b00, clr, endv, 1'b1, endc, tail, 7'd0, 3'b000};
  endfunction

  task automatic access(input logic [31:0] a, input logic wr, input logic [63:0] wd);
    int chip = int'(a[25:24]);
    bit is_data = a[19];
    bit want_busy = is_data && a[20];
    logic [63:0] exp_rd = '0;
    time t_ack;
    int base = rd_ctr;
    logic [CHIPS-1:0] exp_ce;
    if (!is_data) begin
      exp_q.push_back('{cle:1'b1, ale:1'b0, b:a[10:3], chip:chip, tag:"R1"});
      for (int k = 0; k < int'(a[23:21]); k++)
        exp_q.push_back('{cle:1'b0, ale:1'b1, b:wd[8*k +: 8], chip:chip, tag:"R4"});
    end else if (wr) begin
      for (int k = 0; k < DATA_W/8; k++)
        exp_q.push_back('{cle:1'b0, ale:1'b0, b:wd[8*k +: 8], chip:chip,
                          tag:(k == 0) ? "R1" : "R6"});
    end else begin
      for (int k = 0; k < DATA_W/8; k++) exp_rd[8*k +: 8] = pat(base + k);
    end
    if (a[20]) exp_q.push_back('{cle:1'b1, ale:1'b0, b:a[18:11], chip:chip, tag:"R5"});
    arm_busy = want_busy;
    @(negedge clk);
    req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    t_ack = $time;
    chk(exp_q.size() == 0, "R5", "bytes left at ack", exp_q.size(), 0);
    chk(ecc_last == (is_data && a[10]), "R10", "ecc_last", {63'd0, ecc_last},
        {63'd0, is_data && a[10]});
    if (is_data && !wr) chk(rsp_rdata == exp_rd, "R7", "read word", rsp_rdata, exp_rd);
    if (want_busy) chk((rb_rise > t_endcmd) && (t_ack > rb_rise), "R8",
                       "ack after ready", t_ack, rb_rise);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready single cycle", {63'd0, req_ready}, 0);
    chk(ecc_last == 1'b0, "R10", "ecc_last after ack", {63'd0, ecc_last}, 0);
    exp_ce = (is_data && a[21]) ? '1 : ~(CHIPS'(1) << chip);
    chk(nand_ce_n == exp_ce, "R9", "ce after access", {60'd0, nand_ce_n}, {60'd0, exp_ce});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(nand_ce_n == '1 && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
        "R2", "reset pins", {56'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale},
        {56'd0, 4'hf, 4'b1100});
    chk(!req_ready && !ecc_last, "R11", "reset ready", {62'd0, req_ready, ecc_last}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 aliased chip field 0x05 -> chip 1; R10 start opcode has bit 10 set
    access(mk_cmd(8'h05, 3'd5, 1'b0, 8'h00, 8'h80), 1'b0, 64'h0000_0011_2233_4455);
    // R6 R8 R9 R10 data write with closing opcode, release and tail
    access(mk_dat(8'h01, 1'b1, 1'b1, 8'h10, 1'b1), 1'b1, 64'h8877_6655_4433_2211);
    // R9 command with bit 21 set (count 3) keeps the chip enabled
    access(mk_cmd(8'h02, 3'd3, 1'b1, 8'h30, 8'h00), 1'b0, 64'h0000_0000_00CC_BBAA);
    // R7 read, no closing opcode
    access(mk_dat(8'h02, 1'b0, 1'b0, 8'h00, 1'b0), 1'b0, 64'h0);
    // R4 zero address cycles, chip switch
    access(mk_cmd(8'h03, 3'd0, 1'b0, 8'h00, 8'hFF), 1'b0, 64'hDEAD_BEEF_0000_0000);
    // R5 opcode byte present but bit 20 clear
    access(mk_dat(8'h03, 1'b1, 1'b0, 8'hE0, 1'b1), 1'b0, 64'h0);
    access(mk_dat(8'h00, 1'b0, 1'b0, 8'h99, 1'b0), 1'b1, 64'h0102_0304_0506_0708);
    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule